// File: doc/BRIEF.md
# Per-Channel Delay Time Slot Interchanger

This block reorders the byte channels of one time-division multiplexed frame of 32 slots. Every clock cycle carries one slot. A frame pulse marks the cycle that carries channel 0. Incoming bytes are stored in one of two data banks, and the active bank flips at each frame pulse. For every output channel, a connection word is read. It names the source channel and a three-bit delay code. With that, the block chooses the stored byte that appears in that output slot.

The delay code is set per output channel. Code 000 gives the lowest latency: the byte comes from the running frame when its source slot lies at least three slots ahead of the output slot, and from the previous frame otherwise. The latency therefore depends only on the two channel numbers. This suits voice traffic. Code 001 always takes the byte from the previous frame. Every channel then sees exactly one frame of delay, and a whole input frame stays together in one output frame, as wideband data needs. Every other code sends the idle byte 0xFF. A host writes connection words through an address, data and write-enable port.

Top module: `tsi_switch`

## Requirements
- R1: After reset, dout_o is 0xFF and dout_fp_o is 0. Every connection word starts with the idle code, so each output channel carries 0xFF until its word is written.
- R2: fp_i high marks the cycle carrying input channel 0, and later cycles carry channels 1, 2, … in order. The output byte of channel j appears on dout_o in the cycle after input slot j, and dout_fp_o is high in the cycle after fp_i.
- R3: A connection word holds the source channel in bits 4:0 and the delay code in bits 15:13. Bits 12:5 have no effect on the output. A word is written at cm_addr_i on a clock edge with cm_we_i high.
- R4: Code 001 (constant): output channel j in frame f carries input channel src of frame f-1, for any src. The banks swap only at a frame pulse.
- R5: Code 000 (variable) with src+3 <= j: output channel j carries input channel src of the same frame, a delay of j-src slots with a minimum of 3.
- R6: Code 000 with src+3 > j: output channel j carries input channel src of the previous frame, a delay of 32+j-src slots with a maximum of one frame plus 2.
- R7: Any code other than 000 and 001 drives the output channel to 0xFF.
- R8: A host write that lands in the cycle of input slot j for the word of channel j leaves the old word in force for that output slot. The new word takes effect from the next frame. A write to a later channel takes effect within the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slot clock, one channel per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high in the cycle of input channel 0 |
| din_i | input | DATA_W | Input byte of the current slot |
| cm_we_i | input | 1 | Connection word write enable |
| cm_addr_i | input | CH_W | Output channel whose word is written |
| cm_wdata_i | input | CM_W | Connection word: source in 4:0, delay code in 15:13 |
| dout_o | output | DATA_W | Output byte, one cycle behind the input slot |
| dout_fp_o | output | 1 | Marks output channel 0 |

## Verification
In a single cycle the host can rewrite the connection word that is being read to build the output byte of that same slot. The bench provokes this by rewriting every channel's word exactly in its own slot, frame after frame, so that each new set of words must first show the previous setting and only in the following frame the new one. It also writes words for channels both before and after the current slot, in the middle of a frame, and judges each slot against a model that applies a write only after that slot's output is formed.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SRC_LSB  = 0;
  localparam int MODE_LSB = 13;
  localparam int MODE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    TM_VAR   = 3'b000,
    TM_CONST = 3'b001,
    TM_IDLE  = 3'b111
  } tmode_e;
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer #(
  parameter int CH_W = 5,
  parameter int N_CH = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fp_i,
  output logic [CH_W-1:0] cur_slot_o,
  output logic            cur_bank_o,
  output logic [CH_W-1:0] slot_q_o,
  output logic            bank_q_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(N_CH - 1);

  logic [CH_W-1:0] slot_q, slot_d;
  logic            bank_q, bank_d;

  always_comb begin
    if (fp_i) begin
      slot_d = '0;
      bank_d = ~bank_q;
    end else begin
      slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
      bank_d = bank_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST;
      bank_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      bank_q <= bank_d;
    end
  end

  assign cur_slot_o = slot_d;
  assign cur_bank_o = bank_d;
  assign slot_q_o   = slot_q;
  assign bank_q_o   = bank_q;
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int CH_W   = 5,
  parameter int N_CH   = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_bank_i,
  input  logic [CH_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_bank_i,
  input  logic [CH_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [N_CH];
    logic              bank_we;

    assign bank_we = (wr_bank_i == b[0]);

    always_ff @(posedge clk_i) begin
      if (bank_we) mem[wr_addr_i] <= wr_data_i;
    end

    assign bank_rd[b] = mem[rd_addr_i];
  end

  assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int N_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   wr_addr_i,
  input  logic [CH_W-1:0]   wr_src_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic [CH_W-1:0]   rd_addr_i,
  output logic [CH_W-1:0]   rd_src_o,
  output logic [MODE_W-1:0] rd_mode_o
);
  logic [CH_W-1:0]   src_q  [N_CH];
  logic [MODE_W-1:0] mode_q [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) begin
        src_q[i]  <= '0;
        mode_q[i] <= TM_IDLE;
      end
    end else if (we_i) begin
      src_q[wr_addr_i]  <= wr_src_i;
      mode_q[wr_addr_i] <= wr_mode_i;
    end
  end

  assign rd_src_o  = src_q[rd_addr_i];
  assign rd_mode_o = mode_q[rd_addr_i];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int CH_W    = 5,
  parameter int DATA_W  = 8,
  parameter int CM_W    = 16,
  parameter int MIN_GAP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              cm_we_i,
  input  logic [CH_W-1:0]   cm_addr_i,
  input  logic [CM_W-1:0]   cm_wdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_fp_o
);
  localparam int N_CH = 2 ** CH_W;
  localparam int CMP_W = CH_W + 2;
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [CH_W-1:0]   cur_slot, slot_q;
  logic              cur_bank, bank_q;
  logic [CH_W-1:0]   rd_src;
  logic [MODE_W-1:0] rd_mode;
  logic              rd_bank;
  logic [DATA_W-1:0] rd_data;
  logic              use_prev, out_valid;
  logic [DATA_W-1:0] out_d;
  logic [DATA_W-1:0] dout_q;
  logic              dout_fp_q;
  logic              unused_cm_bits;

  assign unused_cm_bits = ^{cm_wdata_i[MODE_LSB-1:SRC_LSB+CH_W]};

  tsi_slot_timer #(.CH_W(CH_W), .N_CH(N_CH)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .fp_i       (fp_i),
    .cur_slot_o (cur_slot),
    .cur_bank_o (cur_bank),
    .slot_q_o   (slot_q),
    .bank_q_o   (bank_q)
  );

  tsi_conn_mem #(.CH_W(CH_W), .N_CH(N_CH)) u_cmem (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .we_i      (cm_we_i),
    .wr_addr_i (cm_addr_i),
    .wr_src_i  (cm_wdata_i[SRC_LSB +: CH_W]),
    .wr_mode_i (cm_wdata_i[MODE_LSB +: MODE_W]),
    .rd_addr_i (cur_slot),
    .rd_src_o  (rd_src),
    .rd_mode_o (rd_mode)
  );

  tsi_data_mem #(.CH_W(CH_W), .N_CH(N_CH), .DATA_W(DATA_W)) u_dmem (
    .clk_i     (clk_i),
    .wr_bank_i (cur_bank),
    .wr_addr_i (cur_slot),
    .wr_data_i (din_i),
    .rd_bank_i (rd_bank),
    .rd_addr_i (rd_src),
    .rd_data_o (rd_data)
  );

  // bank choice per output channel
  always_comb begin
    use_prev  = 1'b1;
    out_valid = 1'b0;
    case (rd_mode)
      TM_VAR: begin
        out_valid = 1'b1;
        use_prev  = (CMP_W'(rd_src) + CMP_W'(MIN_GAP)) > CMP_W'(cur_slot);
      end
      TM_CONST: begin
        out_valid = 1'b1;
        use_prev  = 1'b1;
      end
      default: begin
        out_valid = 1'b0;
        use_prev  = 1'b1;
      end
    endcase
    rd_bank = use_prev ? ~cur_bank : cur_bank;
    out_d   = out_valid ? rd_data : IDLE_BYTE;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q    <= IDLE_BYTE;
      dout_fp_q <= 1'b0;
    end else begin
      dout_q    <= out_d;
      dout_fp_q <= (cur_slot == '0);
    end
  end

  assign dout_o    = dout_q;
  assign dout_fp_o = dout_fp_q;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              fp_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_fp_o,
  input logic [CH_W-1:0]   slot_q,
  input logic              bank_q,
  input logic [MODE_W-1:0] rd_mode
);
  typedef logic [CH_W-1:0] ch_t;
  localparam ch_t LAST = '1;

  assert_fp_marks_out_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    fp_i |=> dout_fp_o);

  assert_slot_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    fp_i |=> (slot_q == '0));

  assert_slot_step_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!fp_i && slot_q != LAST) |=> (slot_q == ch_t'($past(slot_q) + 1'b1)));

  assert_bank_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fp_i |=> $stable(bank_q));

  assert_idle_code_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_mode != TM_VAR && rd_mode != TM_CONST) |=> (dout_o == '1));
endmodule

bind tsi_switch tsi_switch_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .fp_i      (fp_i),
  .dout_o    (dout_o),
  .dout_fp_o (dout_fp_o),
  .slot_q    (slot_q),
  .bank_q    (bank_q),
  .rd_mode   (rd_mode)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        fp_i;
  logic [7:0]  din_i;
  logic        cm_we_i;
  logic [4:0]  cm_addr_i;
  logic [15:0] cm_wdata_i;
  logic [7:0]  dout_o;
  logic        dout_fp_o;

  int n_tests = 0;
  int n_fail  = 0;
  int frame_no = 0;

  logic [7:0]  prev_in [32];
  logic [7:0]  cur_in  [32];
  logic [15:0] m_cm    [32];
  bit          m_written [32];
  bit          wr_en_s   [32];
  logic [4:0]  wr_addr_s [32];
  logic [15:0] wr_word_s [32];

  always #10 clk_i = ~clk_i;

  tsi_switch dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .din_i(din_i),
    .cm_we_i(cm_we_i), .cm_addr_i(cm_addr_i), .cm_wdata_i(cm_wdata_i),
    .dout_o(dout_o), .dout_fp_o(dout_fp_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s frame %0d: actual %h expected %h", req, frame_no, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [2:0] code, input int src);
    return {code, 8'hA5, 5'(src)};
  endfunction

  // drive one frame, checking every output slot against the model
  task automatic run_frame();
    for (int j = 0; j < 32; j++) begin
      logic [2:0] code;
      logic [4:0] src;
      logic [7:0] exp;
      string      tag;
      fp_i       = (j == 0);
      din_i      = 8'((frame_no * 29 + j * 11 + 7) & 255);
      cur_in[j]  = din_i;
      cm_we_i    = wr_en_s[j];
      cm_addr_i  = wr_addr_s[j];
      cm_wdata_i = wr_word_s[j];
      @(negedge clk_i);
      code = m_cm[j][15:13];
      src  = m_cm[j][4:0];
      if (code == 3'b000) begin
        if (int'(src) + 3 <= j) begin exp = cur_in[src];  tag = "R5"; end
        else                    begin exp = prev_in[src]; tag = "R6"; end
        if (m_cm[j][12:5] != 0) tag = {tag, "+R3"};
      end else if (code == 3'b001) begin
        exp = prev_in[src]; tag = "R4";
        if (m_cm[j][12:5] != 0) tag = {tag, "+R3"};
      end else begin
        exp = 8'hFF;
        tag = m_written[j] ? "R7" : "R1";
      end
      if (wr_en_s[j] && wr_addr_s[j] == 5'(j)) tag = {tag, "+R8"};
      check(tag, dout_o, exp);
      if (j < 2) check("R2 frame marker", {7'd0, dout_fp_o}, {7'd0, (j == 0)});
      if (wr_en_s[j]) begin
        m_cm[wr_addr_s[j]]      = wr_word_s[j];
        m_written[wr_addr_s[j]] = 1'b1;
      end
    end
    fp_i    = 1'b0;
    cm_we_i = 1'b0;
    for (int k = 0; k < 32; k++) begin
      prev_in[k] = cur_in[k];
      wr_en_s[k] = 1'b0;
    end
    frame_no++;
  endtask

  task automatic set_own_slot(input int s, input logic [15:0] w);
    wr_en_s[s]   = 1'b1;
    wr_addr_s[s] = 5'(s);
    wr_word_s[s] = w;
  endtask

  task automatic t_reset();
    check("R1 reset dout", dout_o, 8'hFF);
    check("R1 reset marker", {7'd0, dout_fp_o}, 8'd0);
  endtask

  // constant delay, reversed order; channel 31 left at reset value
  task automatic t_constant();
    for (int s = 0; s < 31; s++) set_own_slot(s, word(3'b001, 31 - s));
    run_frame();
    run_frame();
    run_frame();
  endtask

  // variable delay at the gap boundary: src = j-3 and src = j-2
  task automatic t_variable();
    for (int s = 0; s < 32; s++)
      set_own_slot(s, word(3'b000, (s % 2 == 0) ? (s + 29) % 32 : (s + 30) % 32));
    run_frame();
    run_frame();
  endtask

  // mixed codes, including same-channel variable and idle codes
  task automatic t_mixed();
    for (int s = 0; s < 32; s++) begin
      case (s % 4)
        0: set_own_slot(s, word(3'b000, s));
        1: set_own_slot(s, word(3'b001, 0));
        2: set_own_slot(s, word(3'b111, s));
        default: set_own_slot(s, word(3'b010, s));
      endcase
    end
    run_frame();
    run_frame();
  endtask

  // writes to other channels in the middle of a frame
  task automatic t_midframe();
    wr_en_s[3]  = 1'b1; wr_addr_s[3]  = 5'd20; wr_word_s[3]  = word(3'b001, 7);
    wr_en_s[10] = 1'b1; wr_addr_s[10] = 5'd22; wr_word_s[10] = word(3'b000, 2);
    wr_en_s[25] = 1'b1; wr_addr_s[25] = 5'd5;  wr_word_s[25] = word(3'b011, 9);
    wr_en_s[26] = 1'b1; wr_addr_s[26] = 5'd1;  wr_word_s[26] = {3'b001, 8'h00, 5'd30};
    run_frame();
    run_frame();
  endtask

  initial begin
    for (int k = 0; k < 32; k++) begin
      m_cm[k] = 16'hE000; m_written[k] = 1'b0; wr_en_s[k] = 1'b0;
      wr_addr_s[k] = 5'd0; wr_word_s[k] = 16'h0; prev_in[k] = 8'h00; cur_in[k] = 8'h00;
    end
    rst_ni = 1'b0; fp_i = 1'b0; din_i = 8'h00;
    cm_we_i = 1'b0; cm_addr_i = 5'd0; cm_wdata_i = 16'h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_constant();
    t_variable();
    t_mixed();
    t_midframe();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule